// File: doc/BRIEF.md
# CAN Nominal Bit Timing and Receive Sampler

This block divides each nominal CAN bit into time quanta and tracks where the receiver is inside the bit. A bit is a one-quantum synchronisation segment, then a first timing segment, then a second phase segment. The quantum grid comes from a single-cycle enable pulse supplied from outside. The block samples the receive line at the end of the first segment and presents the resulting bit with a one-cycle sample strobe. Every new nominal bit is flagged with a bit-boundary strobe.

The receiver follows the transmitter's clock through synchronisation on falling (recessive `1` to dominant `0`) edges. On an idle bus such an edge restarts the bit outright. On a busy bus the edge moves the bit boundary by the measured phase error, capped at the configured jump width. A majority-vote sampling mode is available. It votes over the final three system-clock cycles of the first segment, so a single-cycle glitch at the sample point is filtered out. Lengths are set by three small code fields. A second-segment code of zero is not legal. It is run as the shortest legal length and reported on an error output.

Top module: `can_bit_timing`

## Requirements
- R1: After reset the bit starts in the sync segment. Each `tq_en` pulse advances one quantum. A bit lasts 1 + (`cfg_tseg1`+1) + (`cfg_tseg2`+1) quanta. `bit_stb` is high for one cycle after the clock edge that opens a new bit.
- R2: `cfg_tseg2` = 0 gives a 2-quantum second segment and drives `cfg_err` high. Any other code gives `cfg_tseg2`+1 quanta with `cfg_err` low.
- R3: In single mode (`cfg_triple`=0), `sample_stb` is high for one cycle after the `tq_en` edge that ends the first segment. `rx_bit` then shows `rx` as it was at that edge. `rx_bit` changes at no other time.
- R4: In vote mode (`cfg_triple`=1), `rx_bit` takes the majority of `rx` at the sampling edge and at the two clock edges before it.
- R5: A falling edge of `rx` while `bus_idle`=1 hard-synchronises. The bit restarts at the sync segment on that clock, `bit_stb` pulses, and no jump-width limit applies.
- R6: A falling edge during the sync segment changes no timing.
- R7: A resynchronising edge at quantum index k (from 0) of the first segment lengthens that segment by min(k+1, jump width).
- R8: A resynchronising edge at quantum index k of the second segment, with e = second-segment length − k, starts the next bit on that clock when e ≤ jump width. Otherwise it shortens the second segment by the jump width.
- R9: Resynchronisation takes place at most once per bit. It happens only on falling edges, and only while `rx_bit` is 1. Rising edges have no effect.
- R10: The jump width is `cfg_sjw`+1 quanta.
- R11: During and right after reset, `rx_bit` is 1 and both strobes are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tq_en | input | 1 | One-cycle pulse per time quantum |
| rx | input | 1 | Receive line, already synchronised (1 = recessive) |
| bus_idle | input | 1 | Bus idle; falling edges hard-synchronise |
| cfg_tseg1 | input | TS1_W | First segment length minus one |
| cfg_tseg2 | input | 3 | Second segment length minus one (0 illegal) |
| cfg_sjw | input | 2 | Jump width minus one |
| cfg_triple | input | 1 | 1 = three-cycle majority sampling |
| rx_bit | output | 1 | Last sampled bit |
| sample_stb | output | 1 | One-cycle pulse when rx_bit is refreshed |
| bit_stb | output | 1 | One-cycle pulse at each new bit |
| cfg_err | output | 1 | Illegal second-segment code in use |

## Verification
The properties assume that the configuration stays stable while the block runs, that `tq_en` is a single-cycle pulse, and that `rx` is already synchronous to `clk`. The stimulus changes configuration only under reset. It spaces quantum pulses four cycles apart and changes `rx` only at chosen cycles inside a quantum. Every resynchronising edge lands on a cycle without a quantum pulse, so the position of the edge within the bit is always known.

// File: rtl/can_bt_pkg.sv
package can_bt_pkg;

  typedef enum logic [1:0] {
    SEG_SYNC = 2'd0,
    SEG_TS1  = 2'd1,
    SEG_TS2  = 2'd2
  } seg_e;

  // Second phase segment length in quanta; code 0 runs as the legal minimum.
  function automatic logic [3:0] ts2_quanta(input logic [2:0] code);
    return (code == 3'd0) ? 4'd2 : ({1'b0, code} + 4'd1);
  endfunction

  // Resynchronisation jump width in quanta.
  function automatic logic [2:0] sjw_quanta(input logic [1:0] code);
    return {1'b0, code} + 3'd1;
  endfunction

  // Majority of three samples.
  function automatic logic vote3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

endpackage

// File: rtl/can_bt_rxfront.sv
// Receive front end: falling-edge detect and three-cycle majority vote.
module can_bt_rxfront (
  input  logic clk,
  input  logic rst_n,
  input  logic rx,
  output logic fall,
  output logic vote
);
  logic rx_d1, rx_d2;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_d1 <= 1'b1;
      rx_d2 <= 1'b1;
    end else begin
      rx_d1 <= rx;
      rx_d2 <= rx_d1;
    end
  end

  assign fall = rx_d1 & ~rx;
  assign vote = can_bt_pkg::vote3(rx, rx_d1, rx_d2);
endmodule

// File: rtl/can_bt_segfsm.sv
// Segment sequencer with hard sync and bounded resynchronisation.
module can_bt_segfsm #(
  parameter int Q_W = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tq_en,
  input  logic               fall,
  input  logic               bus_idle,
  input  logic               rx_bit,
  input  logic [Q_W-1:0]     ts1_len,
  input  logic [Q_W-1:0]     ts2_len,
  input  logic [Q_W-1:0]     sjw_len,
  output can_bt_pkg::seg_e   seg,
  output logic               take_sample,
  output logic               new_bit,
  output logic               hard_sync,
  output logic               resync_ts1,
  output logic               resync_ts2
);
  import can_bt_pkg::*;

  localparam logic [Q_W-1:0] ONE = Q_W'(1);

  seg_e           seg_q;
  logic [Q_W-1:0] q_q, ext_q, shrink_q;
  logic           resynced_q;

  logic           resync_ok, early_start, end_bit;
  logic [Q_W-1:0] late_err, ts2_left, ext_nxt, shrink_nxt, ts1_eff, ts2_eff;

  always_comb begin
    hard_sync   = fall && bus_idle;
    resync_ok   = fall && !bus_idle && !resynced_q && rx_bit;
    resync_ts1  = resync_ok && (seg_q == SEG_TS1);
    resync_ts2  = resync_ok && (seg_q == SEG_TS2);

    late_err    = q_q + ONE;
    ts2_left    = ts2_len - q_q;
    early_start = resync_ts2 && (ts2_left <= sjw_len);

    if (resync_ts1) ext_nxt = (late_err < sjw_len) ? late_err : sjw_len;
    else            ext_nxt = ext_q;
    shrink_nxt  = (resync_ts2 && !early_start) ? sjw_len : shrink_q;

    ts1_eff     = ts1_len + ext_nxt;
    ts2_eff     = ts2_len - shrink_nxt;

    take_sample = tq_en && !hard_sync && (seg_q == SEG_TS1) && (late_err >= ts1_eff);
    end_bit     = tq_en && !hard_sync && !early_start && (seg_q == SEG_TS2)
                  && (late_err >= ts2_eff);
    new_bit     = hard_sync || early_start || end_bit;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seg_q      <= SEG_SYNC;
      q_q        <= '0;
      ext_q      <= '0;
      shrink_q   <= '0;
      resynced_q <= 1'b0;
    end else if (new_bit) begin
      seg_q      <= SEG_SYNC;
      q_q        <= '0;
      ext_q      <= '0;
      shrink_q   <= '0;
      resynced_q <= hard_sync;
    end else begin
      ext_q    <= ext_nxt;
      shrink_q <= shrink_nxt;
      if (resync_ts1 || resync_ts2) resynced_q <= 1'b1;
      if (tq_en) begin
        unique case (seg_q)
          SEG_SYNC: begin
            seg_q <= SEG_TS1;
            q_q   <= '0;
          end
          SEG_TS1: begin
            if (take_sample) begin
              seg_q <= SEG_TS2;
              q_q   <= '0;
            end else begin
              q_q <= late_err;
            end
          end
          SEG_TS2: q_q <= late_err;
          default: begin
            seg_q <= SEG_SYNC;
            q_q   <= '0;
          end
        endcase
      end
    end
  end

  assign seg = seg_q;
endmodule

// File: rtl/can_bit_timing.sv
// CAN nominal bit timing and receive sampling unit.
module can_bit_timing #(
  parameter int TS1_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tq_en,
  input  logic             rx,
  input  logic             bus_idle,
  input  logic [TS1_W-1:0] cfg_tseg1,
  input  logic [2:0]       cfg_tseg2,
  input  logic [1:0]       cfg_sjw,
  input  logic             cfg_triple,
  output logic             rx_bit,
  output logic             sample_stb,
  output logic             bit_stb,
  output logic             cfg_err
);
  import can_bt_pkg::*;

  // Room for the longest first segment plus the largest lengthening.
  localparam int Q_W = TS1_W + 2;

  logic [Q_W-1:0] ts1_len, ts2_len, sjw_len;
  logic           fall, vote;
  seg_e           seg;
  logic           take_sample, new_bit, hard_sync, resync_ts1, resync_ts2;
  logic           rx_bit_q, sample_q, bit_q;

  assign ts1_len = Q_W'(cfg_tseg1) + Q_W'(1);
  assign ts2_len = Q_W'(ts2_quanta(cfg_tseg2));
  assign sjw_len = Q_W'(sjw_quanta(cfg_sjw));
  assign cfg_err = (cfg_tseg2 == 3'd0);

  can_bt_rxfront u_front (
    .clk  (clk),
    .rst_n(rst_n),
    .rx   (rx),
    .fall (fall),
    .vote (vote)
  );

  can_bt_segfsm #(.Q_W(Q_W)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .tq_en      (tq_en),
    .fall       (fall),
    .bus_idle   (bus_idle),
    .rx_bit     (rx_bit_q),
    .ts1_len    (ts1_len),
    .ts2_len    (ts2_len),
    .sjw_len    (sjw_len),
    .seg        (seg),
    .take_sample(take_sample),
    .new_bit    (new_bit),
    .hard_sync  (hard_sync),
    .resync_ts1 (resync_ts1),
    .resync_ts2 (resync_ts2)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_bit_q <= 1'b1;
      sample_q <= 1'b0;
      bit_q    <= 1'b0;
    end else begin
      sample_q <= take_sample;
      bit_q    <= new_bit;
      if (take_sample) rx_bit_q <= cfg_triple ? vote : rx;
    end
  end

  assign rx_bit     = rx_bit_q;
  assign sample_stb = sample_q;
  assign bit_stb    = bit_q;
endmodule

// File: rtl/can_bit_timing_chk.sv
module can_bit_timing_chk (
  input logic             clk,
  input logic             rst_n,
  input logic             tq_en,
  input logic             rx,
  input logic             cfg_triple,
  input logic             rx_bit,
  input logic             sample_stb,
  input logic             bit_stb,
  input logic             hard_sync,
  input logic             resync_ts1,
  input logic             resync_ts2,
  input can_bt_pkg::seg_e seg
);
  import can_bt_pkg::*;

  logic [1:0] since_rst;
  logic       seen_resync;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      since_rst   <= 2'd0;
      seen_resync <= 1'b0;
    end else begin
      if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
      if (seg == SEG_SYNC) seen_resync <= 1'b0;
      else if (resync_ts1 || resync_ts2) seen_resync <= 1'b1;
    end
  end

  AST_STROBES_APART: assert property (@(posedge clk) disable iff (!rst_n)
    !(sample_stb && bit_stb)); // R1
  AST_SAMPLE_ON_QUANTUM: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_stb && since_rst != 2'd0) |-> $past(tq_en)); // R3
  AST_SINGLE_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_stb && since_rst != 2'd0 && !$past(cfg_triple)) |-> (rx_bit == $past(rx))); // R3
  AST_HOLD_BETWEEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!sample_stb && since_rst != 2'd0) |-> $stable(rx_bit)); // R3
  AST_TRIPLE_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_stb && since_rst == 2'd3 && $past(cfg_triple))
      |-> (rx_bit == vote3($past(rx, 1), $past(rx, 2), $past(rx, 3)))); // R4
  AST_HARD_SYNC_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    hard_sync |=> (seg == SEG_SYNC) && bit_stb); // R5
  AST_ONE_RESYNC: assert property (@(posedge clk) disable iff (!rst_n)
    (resync_ts1 || resync_ts2) |-> !seen_resync); // R9
  AST_RESYNC_FROM_RECESSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (resync_ts1 || resync_ts2) |-> (rx_bit && !rx)); // R9
endmodule

bind can_bit_timing can_bit_timing_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .tq_en      (tq_en),
  .rx         (rx),
  .cfg_triple (cfg_triple),
  .rx_bit     (rx_bit),
  .sample_stb (sample_stb),
  .bit_stb    (bit_stb),
  .hard_sync  (hard_sync),
  .resync_ts1 (resync_ts1),
  .resync_ts2 (resync_ts2),
  .seg        (seg)
);

// File: tb/tb_can_bit_timing.sv
`timescale 1ns/1ps
module tb_can_bit_timing;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tq_en = 1'b0;
  logic       rx = 1'b1;
  logic       bus_idle = 1'b0;
  logic [3:0] cfg_tseg1 = 4'd3;
  logic [2:0] cfg_tseg2 = 3'd2;
  logic [1:0] cfg_sjw = 2'd1;
  logic       cfg_triple = 1'b0;
  logic       rx_bit, sample_stb, bit_stb, cfg_err;

  int n_checks = 0;
  int n_fails  = 0;
  int tq_cnt   = 0;

  typedef struct {
    bit    smp;
    int    tq;
    bit    val;
    string req;
  } exp_t;
  exp_t sb[$];

  always #4 clk = ~clk;

  can_bit_timing dut (
    .clk(clk), .rst_n(rst_n), .tq_en(tq_en), .rx(rx), .bus_idle(bus_idle),
    .cfg_tseg1(cfg_tseg1), .cfg_tseg2(cfg_tseg2), .cfg_sjw(cfg_sjw),
    .cfg_triple(cfg_triple), .rx_bit(rx_bit), .sample_stb(sample_stb),
    .bit_stb(bit_stb), .cfg_err(cfg_err)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic push(input bit smp, input int tq, input bit val, input string req);
    exp_t e;
    e.smp = smp; e.tq = tq; e.val = val; e.req = req;
    sb.push_back(e);
  endtask

  // Monitor: compare each strobe against the front of the scoreboard.
  task automatic take(input bit smp);
    exp_t e;
    if (sb.size() == 0) begin
      check(1'b0, "R1", smp ? "unexpected sample at tq" : "unexpected bit at tq", tq_cnt, -1);
      return;
    end
    e = sb.pop_front();
    check(e.smp == smp, e.req, "strobe kind", smp, e.smp);
    check(e.tq == tq_cnt, e.req, "strobe quantum", tq_cnt, e.tq);
    if (smp) check(rx_bit == e.val, e.req, "sampled value", rx_bit, e.val);
  endtask

  always @(posedge clk) begin
    #1;
    if (rst_n) begin
      if (sample_stb) take(1'b1);
      if (bit_stb)    take(1'b0);
    end
  end

  task automatic tick(input logic p, input logic r);
    @(negedge clk);
    tq_en = p;
    rx    = r;
    if (p) tq_cnt++;
  endtask

  // One quantum: pulse tick followed by three quiet ticks, rx given per tick.
  task automatic q4(input logic r0, input logic r1, input logic r2, input logic r3);
    tick(1'b1, r0); tick(1'b0, r1); tick(1'b0, r2); tick(1'b0, r3);
  endtask

  task automatic run(input int n, input logic r);
    for (int i = 0; i < n; i++) q4(r, r, r, r);
  endtask

  task automatic start(input logic [3:0] t1, input logic [2:0] t2, input logic [1:0] sj,
                       input logic tri3, input logic idle);
    @(negedge clk);
    rst_n = 1'b0; tq_en = 1'b0; rx = 1'b1;
    cfg_tseg1 = t1; cfg_tseg2 = t2; cfg_sjw = sj; cfg_triple = tri3; bus_idle = idle;
    repeat (3) @(negedge clk);
    tq_cnt = 0;
    rst_n = 1'b1;
  endtask

  task automatic finish_scn(input string req);
    tick(1'b0, rx);
    check(sb.size() == 0, req, "missing strobes", sb.size(), 0);
    sb.delete();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++; n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  end

  initial begin
    // R11 reset state, R1/R3 nominal timing: TS1=4, TS2=3, SJW=2
    start(4'd3, 3'd2, 2'd1, 1'b0, 1'b0);
    check(rx_bit == 1'b1, "R11", "rx_bit after reset", rx_bit, 1);
    check(!sample_stb && !bit_stb, "R11", "strobes after reset", sample_stb | bit_stb, 0);
    check(cfg_err == 1'b0, "R2", "cfg_err legal code", cfg_err, 0);
    push(1, 5, 1, "R3"); push(0, 8, 0, "R1");
    push(1, 13, 1, "R3"); push(0, 16, 0, "R1");
    push(1, 21, 1, "R3"); push(0, 24, 0, "R1");
    run(24, 1'b1);
    finish_scn("R1");

    // R2 illegal TS2 code runs as 2 quanta
    start(4'd3, 3'd0, 2'd1, 1'b0, 1'b0);
    check(cfg_err == 1'b1, "R2", "cfg_err illegal code", cfg_err, 1);
    push(1, 5, 1, "R2"); push(0, 7, 0, "R2");
    push(1, 12, 1, "R2"); push(0, 14, 0, "R2");
    run(14, 1'b1);
    finish_scn("R2");

    // R6 edge in sync, R9 falling edge while rx_bit is 0
    start(4'd3, 3'd2, 2'd1, 1'b0, 1'b0);
    push(1, 5, 1, "R3"); push(0, 8, 0, "R1");
    push(1, 13, 0, "R6"); push(0, 16, 0, "R6");
    push(1, 21, 0, "R6"); push(0, 24, 0, "R6");
    push(1, 29, 0, "R9"); push(0, 32, 0, "R9");
    run(7, 1'b1); q4(1, 1, 0, 0); run(16, 1'b0);
    q4(0, 0, 1, 1); q4(1, 1, 0, 0); run(6, 1'b0);
    finish_scn("R6");

    // R7 TS1 lengthened by phase error 2 (within SJW 2)
    start(4'd3, 3'd2, 2'd1, 1'b0, 1'b0);
    push(1, 5, 1, "R3"); push(0, 8, 0, "R1");
    push(1, 15, 0, "R7"); push(0, 18, 0, "R7");
    push(1, 23, 0, "R7"); push(0, 26, 0, "R7");
    run(9, 1'b1); q4(1, 1, 0, 0); run(16, 1'b0);
    finish_scn("R7");

    // R10 SJW code 0 caps the same lengthening at 1
    start(4'd3, 3'd2, 2'd0, 1'b0, 1'b0);
    push(1, 5, 1, "R3"); push(0, 8, 0, "R1");
    push(1, 14, 0, "R10"); push(0, 17, 0, "R10");
    run(9, 1'b1); q4(1, 1, 0, 0); run(7, 1'b0);
    finish_scn("R10");

    // R8 TS2=7, SJW=1: shortened by one quantum
    start(4'd3, 3'd6, 2'd0, 1'b0, 1'b0);
    push(1, 5, 1, "R3"); push(0, 11, 0, "R8");
    push(1, 16, 0, "R8"); push(0, 23, 0, "R8");
    run(5, 1'b1); q4(1, 1, 0, 0); run(17, 1'b0);
    finish_scn("R8");

    // R8 TS2=3, SJW=2: error within SJW, next bit starts at once
    start(4'd3, 3'd2, 2'd1, 1'b0, 1'b0);
    push(1, 5, 1, "R3"); push(0, 7, 0, "R8");
    push(1, 12, 0, "R8"); push(0, 15, 0, "R8");
    run(6, 1'b1); q4(1, 1, 0, 0); run(8, 1'b0);
    finish_scn("R8");

    // R9 second falling edge in the same bit is ignored
    start(4'd3, 3'd2, 2'd1, 1'b0, 1'b0);
    push(1, 5, 1, "R3"); push(0, 8, 0, "R1");
    push(1, 14, 0, "R9"); push(0, 17, 0, "R9");
    run(8, 1'b1); q4(1, 1, 0, 0); q4(0, 0, 1, 1); q4(1, 1, 0, 0); run(6, 1'b0);
    finish_scn("R9");

    // R5 hard sync on idle bus inside TS1
    start(4'd3, 3'd2, 2'd1, 1'b0, 1'b1);
    push(1, 5, 1, "R3"); push(0, 8, 0, "R1");
    push(0, 10, 0, "R5"); push(1, 15, 0, "R5"); push(0, 18, 0, "R5");
    run(9, 1'b1); q4(1, 1, 0, 0); run(8, 1'b0);
    finish_scn("R5");

    // R4 majority over the last three cycles of TS1
    start(4'd3, 3'd2, 2'd1, 1'b1, 1'b0);
    push(1, 5, 1, "R4"); push(0, 8, 0, "R1");
    push(1, 13, 0, "R4"); push(0, 16, 0, "R1");
    push(1, 21, 1, "R4"); push(0, 24, 0, "R1");
    push(1, 29, 0, "R4"); push(0, 32, 0, "R1");
    run(7, 1'b1); q4(1, 1, 0, 0); run(11, 1'b0);
    q4(0, 0, 1, 1); run(8, 1'b0); q4(1, 1, 1, 1); run(3, 1'b1);
    finish_scn("R4");

    $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  end
endmodule